// File: doc/BRIEF.md
# Serial Five-Bit Odd-Count Parity Generator

This block reads one data bit on every clock. It splits the incoming stream into back-to-back frames of five bits that do not overlap. It reports on a one-bit output whether each frame holds an odd number of ones. The result is a Mealy output. It is formed from the four bits already stored and the bit on the input at that moment. It is therefore valid in the same cycle as the fifth bit of the frame, with no added cycle of latency.

Frame boundaries come only from a position counter, which steps 0 to 4 and then wraps. The bits seen so far in the current frame sit in a five-bit shift register. Both the counter and the shift register are driven out on debug ports so they can be traced. A synchronous active-low reset clears both and starts a new frame.

Top module: `serial_parity5`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `dbg_pos` becomes 0 and `dbg_shift` becomes 0 after that edge.
- R2: Out of reset, `dbg_pos` increases by one at every rising edge and goes from 4 back to 0, so frames follow each other with no idle cycle.
- R3: While `dbg_pos` is 4, `par_out` is 1 exactly when the four bits stored for the frame plus the current `din` contain an odd number of ones.
- R4: While `dbg_pos` is 0, 1, 2 or 3, `par_out` is 0.
- R5: At an edge with `rst_n` high and `dbg_pos` below 4, `dbg_shift` becomes its old value shifted one place toward the MSB, with `din` entering bit 0. The first bit of a frame therefore ends up in the highest occupied position.
- R6: At an edge with `rst_n` high and `dbg_pos` equal to 4, `dbg_shift` becomes 0. No bit of one frame affects the parity of the next.
- R7: `par_out` follows `din` within the fifth cycle of a frame without waiting for a clock edge. Toggling `din` while `dbg_pos` is 4 toggles `par_out`.
- R8: A reset applied in the middle of a frame discards the partial frame. The five bits that follow the reset form the next complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit, one per clock |
| par_out | output | 1 | Odd-count flag, valid in the fifth cycle of a frame, 0 otherwise |
| dbg_shift | output | FRAME_LEN (5) | Bits stored so far in the current frame |
| dbg_pos | output | $clog2(FRAME_LEN) (3) | Position of the current bit within its frame, 0 to 4 |

## Verification
The stimulus uses several kinds of frame:
- all-zero and all-one frames, which tell an even count from an odd count of five;
- an alternating frame and a single-one frame, which catch a parity that ignores one position or sums the wrong bits;
- a pseudo-random stream over many frames, which catches a wrong wrap point or a shift register that carries bits into the next frame.

A reset in mid-frame shows whether the partial frame is really discarded. Toggling `din` within the fifth cycle, with no clock edge in between, separates a same-cycle Mealy output from one that is registered.

// File: rtl/p5_pkg.sv
// Package: shared defaults for the serial parity generator.
// Assumes nothing beyond a frame length of at least two bits.
package p5_pkg;
    parameter int FRAME_LEN_DEF = 5;
endpackage

// File: rtl/p5_frame_counter.sv
// Module: frame position counter.
// Counts 0 .. FRAME_LEN-1 once per clock and wraps with no gap.
// Assumes a synchronous active-low reset that returns it to 0.
module p5_frame_counter #(
    parameter int FRAME_LEN = p5_pkg::FRAME_LEN_DEF,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] pos,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    // Flag the final slot of a frame.
    always_comb last = (pos == LAST_POS);

    // Advance the position, wrapping after the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (last) pos <= '0;
        else           pos <= pos + 1'b1;
    end

    // R2: the counter steps by one below the last slot
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != LAST_POS) |=> (pos == $past(pos) + 1'b1));
    // R2: the counter wraps to zero after the last slot
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == LAST_POS) |=> (pos == '0));
    // R2: the position never leaves its range
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_POS);
endmodule

// File: rtl/p5_bit_store.sv
// Module: frame bit store.
// Shifts din into bit 0 once per clock and clears itself at the end of a frame.
// Assumes clr is high only in the final slot of a frame.
module p5_bit_store #(
    parameter int FRAME_LEN = p5_pkg::FRAME_LEN_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 din,
    output logic [FRAME_LEN-1:0] bits
);
    logic [FRAME_LEN-1:0] next_bits;

    // Next value of every cell: bit 0 takes din, each other bit takes its lower neighbour.
    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_cell
        if (i == 0) begin : g_head
            always_comb next_bits[i] = din;
        end else begin : g_body
            always_comb next_bits[i] = bits[i-1];
        end
    end

    // Hold the partial frame; clear on reset or at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)   bits <= '0;
        else if (clr) bits <= '0;
        else          bits <= next_bits;
    end

    // R5: the register shifts toward the MSB and takes din in bit 0
    a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (bits == {$past(bits[FRAME_LEN-2:0]), $past(din)}));
endmodule

// File: rtl/p5_parity_out.sv
// Module: Mealy parity output.
// Combines the stored bits with the live input and gates the result to the last slot.
// Assumes the stored bits hold only the current frame.
module p5_parity_out #(
    parameter int FRAME_LEN = p5_pkg::FRAME_LEN_DEF
) (
    input  logic                 last,
    input  logic [FRAME_LEN-2:0] stored,
    input  logic                 din,
    output logic                 par
);
    logic [FRAME_LEN-1:0] chain;

    // Running XOR through the stored bits, seeded with the live input.
    always_comb chain[0] = din;
    for (genvar i = 1; i < FRAME_LEN; i++) begin : g_xor
        always_comb chain[i] = chain[i-1] ^ stored[i-1];
    end

    // Drive the result only in the last slot of the frame.
    always_comb par = last & chain[FRAME_LEN-1];

    // R4: the output stays low outside the last slot
    always_comb begin
        if (!last) a_r4_quiet: assert (par == 1'b0);
    end
endmodule

// File: rtl/serial_parity5.sv
// Module: serial parity generator top.
// Splits din into non-overlapping frames and flags odd-count frames in their final cycle.
// Assumes one data bit per clock and a synchronous active-low reset.
module serial_parity5 #(
    parameter int FRAME_LEN = p5_pkg::FRAME_LEN_DEF,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din,
    output logic                 par_out,
    output logic [FRAME_LEN-1:0] dbg_shift,
    output logic [CNT_W-1:0]     dbg_pos
);
    logic             last;
    logic [CNT_W-1:0] pos;
    logic [FRAME_LEN-1:0] bits;

    p5_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (pos),
        .last  (last)
    );

    p5_bit_store #(.FRAME_LEN(FRAME_LEN)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (last),
        .din   (din),
        .bits  (bits)
    );

    p5_parity_out #(.FRAME_LEN(FRAME_LEN)) u_par (
        .last   (last),
        .stored (bits[FRAME_LEN-2:0]),
        .din    (din),
        .par    (par_out)
    );

    // Expose the internal state for tracing.
    always_comb dbg_shift = bits;
    always_comb dbg_pos   = pos;

    // R1: reset clears both the counter and the bit store
    a_r1_clear: assert property (@(posedge clk)
        !rst_n |=> (pos == '0 && bits == '0));
    // R6: the bit store is empty at the start of every frame
    a_r6_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (bits == '0));
    // R6: at the first slot of a frame nothing is stored yet
    a_r6_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> (bits == '0));
endmodule

// File: tb/serial_parity5_tb.sv
module serial_parity5_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       par_out;
    logic [4:0] dbg_shift;
    logic [2:0] dbg_pos;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    int  pos_m = 0;
    bit  q[$];
    string tag = "";

    always #5 clk = ~clk;

    serial_parity5 u_dut (
        .clk(clk), .rst_n(rst_n), .din(din),
        .par_out(par_out), .dbg_shift(dbg_shift), .dbg_pos(dbg_pos)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_shift();
        int v = 0;
        foreach (q[i]) v = (v << 1) | int'(q[i]);
        return v;
    endfunction

    function automatic int exp_par(bit wv);
        int ones = int'(wv);
        if (pos_m != 4) return 0;
        foreach (q[i]) ones += int'(q[i]);
        return ones % 2;
    endfunction

    // One clock: drive, check the Mealy output, advance the model, check state.
    task automatic step(bit wv, bit rv);
        bit was_last;
        @(negedge clk);
        din = wv; rst_n = rv;
        #2;
        chk(tag != "" ? tag : (pos_m == 4 ? "R3" : "R4"), int'(par_out), exp_par(wv));
        @(posedge clk);
        was_last = (pos_m == 4);
        if (!rv) begin
            pos_m = 0; q.delete();
        end else if (was_last) begin
            pos_m = 0; q.delete();
        end else begin
            q.push_back(wv); pos_m++;
        end
        #1;
        chk(!rv ? "R1" : (tag != "" ? tag : "R2"), int'(dbg_pos), pos_m);
        chk(!rv ? "R1" : (tag != "" ? tag : (was_last ? "R6" : "R5")), int'(dbg_shift), exp_shift());
    endtask

    task automatic frame(bit [4:0] f);
        for (int i = 4; i >= 0; i--) step(f[i], 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        // R1: reset state
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        // R3/R4/R5/R6 with distinct frame patterns
        frame(5'b00000);
        frame(5'b11111);
        frame(5'b10101);
        frame(5'b01000);
        frame(5'b11000);
        frame(5'b01111);
        // R2/R3: long pseudo-random stream
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], 1'b1);
        end
        // R8: reset in mid-frame, partial frame discarded
        while (pos_m != 2) step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        tag = "R8";
        frame(5'b10110);
        frame(5'b00001);
        tag = "";
        // R7: par_out follows din within the fifth cycle
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        @(negedge clk);
        din = 1'b0;
        #1;
        chk("R7", int'(par_out), 0);
        din = 1'b1;
        #1;
        chk("R7", int'(par_out), 1);
        din = 1'b0;
        #1;
        chk("R7", int'(par_out), 0);
        @(posedge clk);
        pos_m = 0; q.delete();
        #1;
        chk("R2", int'(dbg_pos), 0);
        chk("R6", int'(dbg_shift), 0);
        frame(5'b11100);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule